// File: doc/BRIEF.md
# Burst Start Detector by Lagged Self-Correlation

The block watches a stream of signed complex baseband samples and flags the start of a burst whose preamble repeats a 16-sample training pattern many times. For each accepted sample it forms the product of that sample with the complex conjugate of the sample received 16 samples earlier. It sums those products over a sliding window of 32 samples, and it sums the instantaneous power over the same window. While the repeated pattern is present the lagged product stays coherent, so the magnitude of the correlation sum approaches the energy sum. Noise or unrelated data keeps it well below.

A sample counts as a hit when the squared correlation magnitude exceeds a programmable fraction of the squared energy. Both sides are cross-multiplied, so no divider is needed. The detect flag rises after a programmable number of consecutive hits and stays high until a clear pulse. The running correlation sum is also driven out on every sample, so that a later stage can estimate the coarse carrier offset from its angle. Both window sums are kept recursively: each accepted sample adds the newest term and subtracts the term that leaves the window.

Top module: `burst_detect`

## Requirements
- R1: While reset is asserted and after it is released, detect and corrValid are low and corrRe/corrIm are zero. The lag line, the product history and both window sums are cleared, so samples from before reset contribute zero.
- R2: After accepted sample n, corrRe + j·corrIm equals the sum over the 32 most recent accepted samples k of r(k)·conj(r(k-16)). For r = a+jb and the lagged sample c+jd, the real part is a·c+b·d and the imaginary part is b·c-a·d. Lagged samples that lie before reset count as zero.
- R3: A sample is a hit when (corrRe² + corrIm²)·256 > thrFrac·P². P is the sum of I²+Q² over the same 32 samples, and thrFrac is an 8-bit unsigned fraction of 256. Equality is not a hit.
- R4: corrValid is high for exactly one clock cycle per accepted sample. It rises after the second rising edge counted from the edge that accepts the sample (inValid high), and the new corrRe/corrIm appear in that same cycle.
- R5: The block accepts one sample on every clock with inValid held high, and produces one corrValid strobe per sample with the correct sums.
- R6: Hits produced by the first 47 samples after reset are not counted. The 48th sample is the first whose hit counts, because its window then holds only fully lagged products.
- R7: detect rises on the third rising edge after the sample that completes runLen consecutive counted hits. A runLen of 0 acts as 1. A sample that is not a counted hit restarts the run.
- R8: Once high, detect stays high until clearDet is sampled high. clearDet drops detect on that edge and restarts the run. A hit arriving on the same edge as clearDet is discarded.
- R9: clearDet does not touch the lag line, the product history or the window sums. Correlation outputs after a clear continue exactly as if no clear had occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe, one sample per clock when high |
| inI | input | 8 | In-phase sample, signed |
| inQ | input | 8 | Quadrature sample, signed |
| thrFrac | input | 8 | Detection threshold, unsigned fraction of 256 |
| runLen | input | 8 | Consecutive counted hits required for detect (0 acts as 1) |
| clearDet | input | 1 | Clears the detect flag and the hit run |
| corrValid | output | 1 | Strobe marking a new correlation sum |
| corrRe | output | 22 | Real part of the windowed correlation, signed |
| corrIm | output | 22 | Imaginary part of the windowed correlation, signed |
| detect | output | 1 | Sticky burst detect flag |

## Verification
The detector is driven with an exactly 16-periodic complex pattern, a pseudo-random sequence and all-zero input. These inputs separate a coherent window (ratio one) from an incoherent one, and they expose the equality case where correlation and energy are both zero. Periodic bursts of 47 and 48 samples bracket the fill boundary. A run length longer than the burst, a run length of zero and a random segment spliced into a periodic burst separate the consecutive-hit counting from a plain hit count. Back-to-back streaming, clears with and without a coincident hit, and streams continued after a clear show that the window sums are independent of the detect control.

// File: rtl/burst_detect_pkg.sv
package burst_detect_pkg;

  // enables for the three pipeline stages, driven by the control
  typedef struct packed {
    logic ld1;  // lag line shift and lagged product register
    logic ld2;  // product history shift and window sum update
    logic ld3;  // threshold comparison register
  } stageStb_t;

  function automatic int prodW(input int dataW);
    return 2 * dataW + 1;
  endfunction

  function automatic int accW(input int dataW, input int win);
    return 2 * dataW + 1 + $clog2(win);
  endfunction

  function automatic int pwrAccW(input int dataW, input int win);
    return 2 * dataW + $clog2(win);
  endfunction

endpackage

// File: rtl/burst_detect_shift.sv
module burst_detect_shift #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] taps [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)   taps[i] <= '0;
        else if (en) taps[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)   taps[i] <= '0;
        else if (en) taps[i] <= taps[i-1];
      end
    end
  end

  assign dout = taps[DEPTH-1];

endmodule

// File: rtl/burst_detect_dp.sv
module burst_detect_dp
  import burst_detect_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LAG    = 16,
  parameter int WIN    = 32,
  parameter int THR_W  = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  stageStb_t                           stb,
  input  logic signed [DATA_W-1:0]            inI,
  input  logic signed [DATA_W-1:0]            inQ,
  input  logic [THR_W-1:0]                    thrFrac,
  output logic signed [accW(DATA_W,WIN)-1:0]  corrRe,
  output logic signed [accW(DATA_W,WIN)-1:0]  corrIm,
  output logic                                hit
);

  localparam int PROD_W = prodW(DATA_W);
  localparam int POW_W  = 2 * DATA_W;
  localparam int ACC_W  = accW(DATA_W, WIN);
  localparam int PACC_W = pwrAccW(DATA_W, WIN);
  localparam int HIST_W = 2 * PROD_W + POW_W;
  localparam int CMP_W  = 2 * ACC_W + THR_W + 1;

  // stage 1: lagged sample and conjugate product
  logic [2*DATA_W-1:0]       lagOut;
  logic signed [DATA_W-1:0]  oldI, oldQ;

  burst_detect_shift #(.WIDTH(2*DATA_W), .DEPTH(LAG)) u_lagLine (
    .clk (clk),
    .rstN(rstN),
    .en  (stb.ld1),
    .din ({inI, inQ}),
    .dout(lagOut)
  );

  assign {oldI, oldQ} = lagOut;

  logic signed [2*DATA_W-1:0] mAC, mBD, mBC, mAD, mAA, mBB;
  assign mAC = inI * oldI;
  assign mBD = inQ * oldQ;
  assign mBC = inQ * oldI;
  assign mAD = inI * oldQ;
  assign mAA = inI * inI;
  assign mBB = inQ * inQ;

  logic signed [PROD_W-1:0] prodRe, prodIm;
  logic [POW_W-1:0]         pwrNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodRe <= '0;
      prodIm <= '0;
      pwrNow <= '0;
    end else if (stb.ld1) begin
      prodRe <= PROD_W'(mAC) + PROD_W'(mBD);
      prodIm <= PROD_W'(mBC) - PROD_W'(mAD);
      pwrNow <= POW_W'(mAA) + POW_W'(mBB);
    end
  end

  // stage 2: recursive window sums
  logic [HIST_W-1:0]        histOut;
  logic signed [PROD_W-1:0] leaveRe, leaveIm;
  logic [POW_W-1:0]         leaveP;

  burst_detect_shift #(.WIDTH(HIST_W), .DEPTH(WIN)) u_history (
    .clk (clk),
    .rstN(rstN),
    .en  (stb.ld2),
    .din ({prodRe, prodIm, pwrNow}),
    .dout(histOut)
  );

  assign {leaveRe, leaveIm, leaveP} = histOut;

  logic signed [ACC_W-1:0] accRe, accIm;
  logic [PACC_W-1:0]       accP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accRe <= '0;
      accIm <= '0;
      accP  <= '0;
    end else if (stb.ld2) begin
      accRe <= accRe + ACC_W'(prodRe) - ACC_W'(leaveRe);
      accIm <= accIm + ACC_W'(prodIm) - ACC_W'(leaveIm);
      accP  <= accP + PACC_W'(pwrNow) - PACC_W'(leaveP);
    end
  end

  // stage 3: division-free threshold test
  logic signed [2*ACC_W-1:0] sqRe, sqIm;
  logic [CMP_W-1:0]          lhs, rhs;

  assign sqRe = accRe * accRe;
  assign sqIm = accIm * accIm;
  assign lhs  = (CMP_W'($unsigned(sqRe)) + CMP_W'($unsigned(sqIm))) << THR_W;
  assign rhs  = CMP_W'(thrFrac) * CMP_W'(accP) * CMP_W'(accP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hit <= 1'b0;
    else if (stb.ld3) hit <= (lhs > rhs);
  end

  assign corrRe = accRe;
  assign corrIm = accIm;

endmodule

// File: rtl/burst_detect_ctl.sv
module burst_detect_ctl
  import burst_detect_pkg::*;
#(
  parameter int LAG   = 16,
  parameter int WIN   = 32,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             hit,
  input  logic             clearDet,
  input  logic [RUN_W-1:0] runLen,
  output stageStb_t        stb,
  output logic             corrValid,
  output logic             detect
);

  localparam int FILL = LAG + WIN;
  localparam int FCW  = $clog2(FILL);

  logic           v1, v2, v3;
  logic [FCW-1:0] fillCnt;
  logic [RUN_W-1:0] runCnt;
  logic           filled;
  logic [RUN_W:0] runNext, target;

  assign stb.ld1   = inValid;
  assign stb.ld2   = v1;
  assign stb.ld3   = v2;
  assign corrValid = v2;

  assign filled  = (fillCnt == FCW'(FILL - 1));
  assign runNext = {1'b0, runCnt} + (RUN_W+1)'(1);
  assign target  = (runLen == '0) ? (RUN_W+1)'(1) : {1'b0, runLen};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      v3      <= 1'b0;
      fillCnt <= '0;
      runCnt  <= '0;
      detect  <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
      if (v3 && !filled) fillCnt <= fillCnt + FCW'(1);
      if (clearDet) begin
        detect <= 1'b0;
        runCnt <= '0;
      end else if (v3) begin
        if (hit && filled) begin
          if (runNext >= target) detect <= 1'b1;
          if (runCnt != '1) runCnt <= runCnt + RUN_W'(1);
        end else begin
          runCnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/burst_detect.sv
module burst_detect
  import burst_detect_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LAG    = 16,
  parameter int WIN    = 32,
  parameter int THR_W  = 8,
  parameter int RUN_W  = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  input  logic signed [DATA_W-1:0]           inI,
  input  logic signed [DATA_W-1:0]           inQ,
  input  logic [THR_W-1:0]                   thrFrac,
  input  logic [RUN_W-1:0]                   runLen,
  input  logic                               clearDet,
  output logic                               corrValid,
  output logic signed [accW(DATA_W,WIN)-1:0] corrRe,
  output logic signed [accW(DATA_W,WIN)-1:0] corrIm,
  output logic                               detect
);

  stageStb_t stb;
  logic      hit;

  burst_detect_ctl #(.LAG(LAG), .WIN(WIN), .RUN_W(RUN_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .hit      (hit),
    .clearDet (clearDet),
    .runLen   (runLen),
    .stb      (stb),
    .corrValid(corrValid),
    .detect   (detect)
  );

  burst_detect_dp #(.DATA_W(DATA_W), .LAG(LAG), .WIN(WIN), .THR_W(THR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .inI    (inI),
    .inQ    (inQ),
    .thrFrac(thrFrac),
    .corrRe (corrRe),
    .corrIm (corrIm),
    .hit    (hit)
  );

endmodule

// File: rtl/burst_detect_chk.sv
module burst_detect_chk #(
  parameter int LAG   = 16,
  parameter int WIN   = 32,
  parameter int ACC_W = 22
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             clearDet,
  input logic             corrValid,
  input logic [ACC_W-1:0] corrRe,
  input logic [ACC_W-1:0] corrIm,
  input logic             detect
);

  localparam int FILL = LAG + WIN;
  localparam int SCW  = $clog2(FILL + 1);

  logic [SCW-1:0] strobeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeCnt <= '0;
    else if (corrValid && strobeCnt != SCW'(FILL)) strobeCnt <= strobeCnt + SCW'(1);
  end

  // R1: reset holds the outputs low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!detect && !corrValid));

  // R4: one strobe per accepted sample, two edges later
  assert_corr_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |-> (corrValid == $past(inValid, 2)));

  // R2: the correlation sums move only with their strobe
  assert_corr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !corrValid |-> ($stable(corrRe) && $stable(corrIm)));

  // R6: no detect before the window holds only lagged products
  assert_no_early_detect_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detect) |-> (strobeCnt >= SCW'(FILL)));

  // R8: detect is sticky while no clear arrives
  assert_detect_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (detect && !clearDet) |=> detect);

  // R8: a clear always wins
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearDet |=> !detect);

endmodule

bind burst_detect burst_detect_chk #(
  .LAG  (LAG),
  .WIN  (WIN),
  .ACC_W(burst_detect_pkg::accW(DATA_W, WIN))
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .clearDet (clearDet),
  .corrValid(corrValid),
  .corrRe   (corrRe),
  .corrIm   (corrIm),
  .detect   (detect)
);

// File: tb/test_burst_detect.sv
module test_burst_detect;
  import burst_detect_pkg::*;

  localparam int DATA_W = 8;
  localparam int LAG    = 16;
  localparam int WIN    = 32;
  localparam int THR_W  = 8;
  localparam int RUN_W  = 8;
  localparam int ACC_W  = accW(DATA_W, WIN);
  localparam int FILL   = LAG + WIN;

  // pattern (0 periodic, 1 random, 2 zero), thrFrac, runLen, length, expected detect
  localparam int NROW = 6;
  localparam int TBL [NROW][5] = '{
    '{0, 128,  4, 80, 1},
    '{1, 128,  4, 80, 0},
    '{2,   0,  1, 80, 0},
    '{0, 128, 40, 60, 0},
    '{0,   0,  1, 47, 0},
    '{0,   0,  1, 48, 1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                     rstN = 1'b0;
  logic                     inValid = 1'b0;
  logic signed [DATA_W-1:0] inI = '0, inQ = '0;
  logic [THR_W-1:0]         thrFrac = '0;
  logic [RUN_W-1:0]         runLen = '0;
  logic                     clearDet = 1'b0;
  logic                     corrValid;
  logic signed [ACC_W-1:0]  corrRe, corrIm;
  logic                     detect;

  burst_detect #(.DATA_W(DATA_W), .LAG(LAG), .WIN(WIN), .THR_W(THR_W), .RUN_W(RUN_W))
  i_burst_detect (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .thrFrac(thrFrac), .runLen(runLen), .clearDet(clearDet),
    .corrValid(corrValid), .corrRe(corrRe), .corrIm(corrIm), .detect(detect)
  );

  int checks = 0;
  int errors = 0;
  int sI [0:1023];
  int sQ [0:1023];
  int nSamp = 0;
  int mRun = 0;
  bit mDet = 1'b0;
  int curThr = 0;
  int curRun = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelCorr(input int k, output longint cr, output longint ci, output longint p);
    cr = 0; ci = 0; p = 0;
    for (int j = k - WIN + 1; j <= k; j++) begin
      if (j >= 1) begin
        longint a = sI[j];
        longint b = sQ[j];
        longint c = (j - LAG >= 1) ? sI[j-LAG] : 0;
        longint d = (j - LAG >= 1) ? sQ[j-LAG] : 0;
        cr += a * c + b * d;
        ci += b * c - a * d;
        p  += a * a + b * b;
      end
    end
  endtask

  task automatic modelStore(input int i, input int q);
    longint cr, ci, p;
    bit hit;
    int tgt;
    nSamp++;
    sI[nSamp] = i;
    sQ[nSamp] = q;
    modelCorr(nSamp, cr, ci, p);
    hit = ((cr * cr + ci * ci) * (64'sd1 << THR_W)) > (longint'(curThr) * p * p);
    tgt = (curRun == 0) ? 1 : curRun;
    if (nSamp >= FILL && hit) begin
      mRun++;
      if (mRun >= tgt) mDet = 1'b1;
    end else begin
      mRun = 0;
    end
  endtask

  task automatic genSample(input int pat, input int idx, output int i, output int q);
    int m;
    case (pat)
      0: begin
        m = idx % 16;
        i = m * 13 - 97;
        q = 90 - m * 11;
      end
      1: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        i = int'($signed(lfsr[7:0]));
        q = int'($signed(lfsr[15:8]));
      end
      default: begin
        i = 0;
        q = 0;
      end
    endcase
  endtask

  task automatic setCfg(input int thr, input int run);
    @(negedge clk);
    thrFrac = THR_W'(thr);
    runLen  = RUN_W'(run);
    curThr  = thr;
    curRun  = run;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    clearDet = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(detect == 1'b0, "R1 detect", detect, 0);
    check(corrValid == 1'b0, "R1 corrValid", corrValid, 0);
    rstN = 1'b1;
    nSamp = 0;
    mRun = 0;
    mDet = 1'b0;
    lfsr = 16'hACE1;
    @(negedge clk);
    check(corrRe == 0 && corrIm == 0, "R1 corr", longint'(corrRe), 0);
  endtask

  // one sample, then let it travel through the whole pipeline
  task automatic pushSample(input int i, input int q, input string tag);
    longint cr, ci, p;
    @(negedge clk);
    inI = DATA_W'(i);
    inQ = DATA_W'(q);
    inValid = 1'b1;
    modelStore(i, q);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(corrValid == 1'b0, "R4 early", corrValid, 0);
    @(posedge clk);
    @(negedge clk);
    modelCorr(nSamp, cr, ci, p);
    check(corrValid == 1'b1, "R4 strobe", corrValid, 1);
    check(longint'(corrRe) == cr, {tag, " re"}, longint'(corrRe), cr);
    check(longint'(corrIm) == ci, {tag, " im"}, longint'(corrIm), ci);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(detect == mDet, "R7 detect", detect, mDet);
  endtask

  task automatic pushPattern(input int pat, input int count, input string tag);
    int i, q;
    for (int s = 0; s < count; s++) begin
      genSample(pat, nSamp + 1, i, q);
      pushSample(i, q, tag);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clearDet = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clearDet = 1'b0;
    mDet = 1'b0;
    mRun = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    longint cr, ci, p;
    int i, q;
    int strobes;

    // table walk: R2, R3, R6, R7
    for (int r = 0; r < NROW; r++) begin
      doReset();
      setCfg(TBL[r][1], TBL[r][2]);
      pushPattern(TBL[r][0], TBL[r][3], "R2");
      case (r)
        0, 3:    tag = "R7 final";
        1, 2:    tag = "R3 final";
        default: tag = "R6 final";
      endcase
      check(detect == TBL[r][4][0], tag, detect, TBL[r][4]);
      check(detect == mDet, tag, detect, mDet);
    end

    // R5: back-to-back stream
    doReset();
    setCfg(128, 4);
    strobes = 0;
    for (int s = 1; s <= 74; s++) begin
      @(negedge clk);
      if (corrValid) begin
        strobes++;
        modelCorr(strobes, cr, ci, p);
        check(longint'(corrRe) == cr, "R5 re", longint'(corrRe), cr);
        check(longint'(corrIm) == ci, "R5 im", longint'(corrIm), ci);
      end
      if (s <= 70) begin
        genSample(0, nSamp + 1, i, q);
        inI = DATA_W'(i);
        inQ = DATA_W'(q);
        inValid = 1'b1;
        modelStore(i, q);
      end else begin
        inValid = 1'b0;
      end
      @(posedge clk);
    end
    check(strobes == 70, "R5 strobe count", strobes, 70);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(detect == mDet, "R5 detect", detect, mDet);

    // R8, R9: clear and re-arm
    doReset();
    setCfg(128, 4);
    pushPattern(0, 60, "R2");
    check(detect == 1'b1, "R8 set", detect, 1);
    pulseClear();
    check(detect == 1'b0, "R8 clear", detect, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(detect == 1'b0, "R8 stays clear", detect, 0);
    pushPattern(0, 3, "R9");
    check(detect == 1'b0, "R7 partial run", detect, 0);
    pushPattern(0, 1, "R9");
    check(detect == 1'b1, "R7 run complete", detect, 1);

    // R8: clear on the same edge as a counted hit
    genSample(0, nSamp + 1, i, q);
    @(negedge clk);
    inI = DATA_W'(i);
    inQ = DATA_W'(q);
    inValid = 1'b1;
    modelStore(i, q);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    clearDet = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clearDet = 1'b0;
    mDet = 1'b0;
    mRun = 0;
    check(detect == 1'b0, "R8 clear priority", detect, 0);
    pushPattern(0, 3, "R9");
    check(detect == 1'b0, "R8 hit discarded", detect, 0);
    pushPattern(0, 1, "R9");
    check(detect == 1'b1, "R8 rearm", detect, 1);

    // R7: runLen zero acts as one
    doReset();
    setCfg(128, 0);
    pushPattern(0, 48, "R2");
    check(detect == 1'b1, "R7 zero run", detect, 1);

    // R7: a break restarts the run
    doReset();
    setCfg(200, 5);
    pushPattern(0, 51, "R2");
    check(detect == 1'b0, "R7 run of four", detect, 0);
    pushPattern(1, 20, "R2");
    pushPattern(0, 60, "R2");
    check(detect == mDet, "R7 after break", detect, mDet);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule